// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures a slow, free-running clock against the fast reference clock it runs on. It selects one of several slow clock sources, brings the selected clock into the reference domain through a flop synchronizer and detects its rising edges there. It then counts reference cycles across a programmed number of slow periods. The host divides the count by the period count and the reference frequency to get the slow period. It can also compare the count against the value it expects.

A measurement runs in one of two ways. In one-shot mode the host raises `start_i` from 0 to 1, waits for `ready_o` and reads `result_o`. In continuous mode (`cont_en_i` high) windows follow each other back to back and `result_o` refreshes after each one. A period count of zero turns a one-shot request into a wait for the next slow rising edge. If the slow clock is dead, the block stays busy and never reports ready, so timeouts belong to the host. All control and status pins are plain levels. The block moves no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `slowcal_meter`

## Requirements
- R1: After the window opens on a detected slow rising edge, `result_o` equals the number of reference cycles up to the N-th following detected slow rising edge, where N is `period_i`. For a slow clock of P reference cycles per period this is N*P. `ready_o` is high when the value appears.
- R2: `src_sel_i` value k selects `src_clk_i[k]` as the measured clock. Values 0 to 3 map to the four inputs.
- R3: A 0-to-1 transition of `start_i` starts a new measurement. `ready_o` is low in the cycle after that edge and stays low until the window completes.
- R4: Holding `start_i` high after a measurement completes does not start another one. `ready_o` stays high and `result_o` stays unchanged.
- R5: With `period_i` zero, a start makes `ready_o` rise within P+4 reference cycles, at the next detected slow rising edge, and `result_o` reads 0.
- R6: With `cont_en_i` high, windows repeat back to back. Once the first window completes, `ready_o` stays high, and each later window reloads `period_i` and refreshes `result_o`.
- R7: With `cont_en_i` high out of reset, measurement begins without any start edge.
- R8: The reference counter saturates at all ones (2^CNT_W-1) and does not wrap. A window longer than that reports all ones.
- R9: If the selected slow clock is stopped, `ready_o` stays low after a start for as long as the clock stays stopped.
- R10: While and right after reset, `ready_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | NSRC | Candidate slow clocks (crystal, divided fast RC, slow RC, slow-clock mux output) |
| src_sel_i | input | $clog2(NSRC) | Index of the measured slow clock |
| period_i | input | PER_W | Number of slow periods per window |
| start_i | input | 1 | One-shot request, acted on at its rising edge |
| cont_en_i | input | 1 | Continuous measurement enable |
| ready_o | output | 1 | Measurement complete |
| result_o | output | CNT_W | Reference cycles counted in the last window |

## Verification
The bench builds the block with CNT_W=8 and PER_W=4, so a single sweep covers every period count from 0 to 15. The saturation point of 255 cycles can then be reached in a few hundred cycles. Four slow sources with periods of 4, 6, 10 and 20 reference cycles are swept over all one-shot period counts. The product N*P crosses 255 on the slowest source, which places both exact counts and saturated counts in the same sweep.

// File: rtl/slowcal_pkg.sv
package slowcal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_ARM  = 2'd1,
    CAL_RUN  = 2'd2
  } cal_state_e;
endpackage

// File: rtl/slowcal_src_mux.sv
module slowcal_src_mux #(
  parameter int NSRC  = 4,
  parameter int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  src_clk_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             sel_clk_o
);
  always_comb begin
    sel_clk_o = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_i == SEL_W'(i)) sel_clk_o = src_clk_i[i];
    end
  end
endmodule

// File: rtl/slowcal_edge_sync.sv
module slowcal_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // A synchronized rise is a one-cycle pulse.
  assert_single_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/slowcal_window.sv
module slowcal_window
  import slowcal_pkg::*;
#(
  parameter int CNT_W = 25,
  parameter int PER_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_rise_i,
  input  logic             start_i,
  input  logic             cont_en_i,
  input  logic [PER_W-1:0] period_i,
  output logic             ready_o,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PER_W-1:0] PER_ONE = PER_W'(1);

  cal_state_e       state_q;
  logic             start_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PER_W-1:0] scnt_q;
  logic [PER_W-1:0] n_q;
  logic             ready_q;
  logic [CNT_W-1:0] result_q;

  logic             start_rise;
  logic [CNT_W-1:0] cnt_inc;
  logic [PER_W-1:0] scnt_inc;
  logic             period_zero;

  assign start_rise  = start_i & ~start_q;
  assign cnt_inc     = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
  assign scnt_inc    = scnt_q + PER_ONE;
  assign period_zero = (period_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CAL_IDLE;
      start_q  <= 1'b0;
      cnt_q    <= '0;
      scnt_q   <= '0;
      n_q      <= '0;
      ready_q  <= 1'b0;
      result_q <= '0;
    end else begin
      start_q <= start_i;
      if (start_rise) begin
        state_q <= CAL_ARM;
        ready_q <= 1'b0;
      end else begin
        unique case (state_q)
          CAL_IDLE: if (cont_en_i) state_q <= CAL_ARM;
          CAL_ARM: begin
            if (slow_rise_i) begin
              if (period_zero) begin
                ready_q  <= 1'b1;
                result_q <= '0;
                state_q  <= cont_en_i ? CAL_ARM : CAL_IDLE;
              end else begin
                state_q <= CAL_RUN;
                cnt_q   <= '0;
                scnt_q  <= '0;
                n_q     <= period_i;
              end
            end
          end
          CAL_RUN: begin
            if (slow_rise_i) begin
              if (scnt_inc == n_q) begin
                result_q <= cnt_inc;
                ready_q  <= 1'b1;
                if (!cont_en_i) begin
                  state_q <= CAL_IDLE;
                end else if (period_zero) begin
                  state_q <= CAL_ARM;
                end else begin
                  cnt_q  <= '0;
                  scnt_q <= '0;
                  n_q    <= period_i;
                end
              end else begin
                scnt_q <= scnt_inc;
                cnt_q  <= cnt_inc;
              end
            end else begin
              cnt_q <= cnt_inc;
            end
          end
          default: state_q <= CAL_IDLE;
        endcase
      end
    end
  end

  assign ready_o  = ready_q;
  assign result_o = result_q;

  assert_ready_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_i) |=> !ready_o);

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CAL_RUN && !slow_rise_i && !start_rise && cnt_q == CNT_MAX)
      |=> cnt_q == CNT_MAX);

  assert_result_with_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> ready_o);

  assert_zero_request_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CAL_ARM && slow_rise_i && period_zero && !start_rise)
      |=> (ready_o && result_o == '0));
endmodule

// File: rtl/slowcal_meter.sv
module slowcal_meter #(
  parameter int NSRC        = 4,
  parameter int CNT_W       = 25,
  parameter int PER_W       = 15,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_clk_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             start_i,
  input  logic             cont_en_i,
  output logic             ready_o,
  output logic [CNT_W-1:0] result_o
);
  logic sel_clk;
  logic slow_rise;

  slowcal_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
    .src_clk_i (src_clk_i),
    .sel_i     (src_sel_i),
    .sel_clk_o (sel_clk)
  );

  slowcal_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sel_clk),
    .rise_o  (slow_rise)
  );

  slowcal_window #(.CNT_W(CNT_W), .PER_W(PER_W)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slow_rise_i (slow_rise),
    .start_i     (start_i),
    .cont_en_i   (cont_en_i),
    .period_i    (period_i),
    .ready_o     (ready_o),
    .result_o    (result_o)
  );
endmodule

// File: tb/sim_slowcal_meter.sv
module sim_slowcal_meter;
  localparam int CNT_W = 8;
  localparam int PER_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] src_clk;
  logic [1:0] src_sel = '0;
  logic [PER_W-1:0] period = '0;
  logic start = 1'b0;
  logic cont_en = 1'b1;
  logic ready;
  logic [CNT_W-1:0] result;

  int total = 0;
  int fails = 0;
  int sp [4] = '{4, 6, 10, 20};
  int sctr [4] = '{0, 0, 0, 0};
  logic [3:0] run = 4'hF;

  always #2 clk = ~clk;

  // Slow sources, synchronous to the reference, P/2 cycles high.
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      sctr[i] <= (sctr[i] + 1) % sp[i];
      src_clk[i] <= run[i] && (sctr[i] < sp[i] / 2);
    end
  end
  initial src_clk = '0;

  slowcal_meter #(.NSRC(4), .CNT_W(CNT_W), .PER_W(PER_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src_clk), .src_sel_i(src_sel),
    .period_i(period), .start_i(start), .cont_en_i(cont_en),
    .ready_o(ready), .result_o(result));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ready(input int limit, output int cyc);
    cyc = 0;
    while (!ready && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic fire_start();
    @(negedge clk) start = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL R1 watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int cyc;
    int exp;
    int ok;
    period = 4'd2;
    src_sel = 2'd0;
    repeat (5) @(negedge clk);
    chk("R10 ready in reset", ready, 0);
    chk("R10 result in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", ready, 0);
    chk("R10 result after reset", result, 0);

    // R7 / R6: continuous runs from reset with no start
    wait_ready(200, cyc);
    chk("R7 ready without start", ready, 1);
    chk("R7 continuous count", result, 8);
    ok = 1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (!ready || result != 8) ok = 0;
    end
    chk("R6 ready held and result steady", ok, 1);
    period = 4'd5;
    repeat (60) @(negedge clk);
    chk("R6 new period picked up", result, 20);
    chk("R6 ready still high", ready, 1);
    cont_en = 1'b0;
    repeat (40) @(negedge clk);

    // R1/R2/R3/R8 sweep over all sources and period counts
    for (int s = 0; s < 4; s++) begin
      for (int n = 1; n < 16; n++) begin
        src_sel = 2'(s);
        period = PER_W'(n);
        fire_start();
        chk($sformatf("R3 ready drop s%0d n%0d", s, n), ready, 0);
        wait_ready(n * sp[s] + 2 * sp[s] + 20, cyc);
        exp = (n * sp[s] > CMAX) ? CMAX : n * sp[s];
        if (exp == CMAX) chk($sformatf("R8 saturate s%0d n%0d", s, n), result, exp);
        else chk($sformatf("R1 R2 count s%0d n%0d", s, n), result, exp);
      end
    end

    // R4: start held high does not retrigger
    ok = 1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!ready || result != CMAX) ok = 0;
    end
    chk("R4 held start ignored", ok, 1);

    // R5: zero count waits for next slow edge
    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s);
      period = '0;
      fire_start();
      wait_ready(200, cyc);
      chk($sformatf("R5 wait within P+4 s%0d", s), (cyc + 1 <= sp[s] + 4) ? 1 : 0, 1);
      chk($sformatf("R5 result zero s%0d", s), result, 0);
    end

    // R9: stopped slow clock
    run[2] = 1'b0;
    src_sel = 2'd2;
    period = 4'd3;
    fire_start();
    ok = 1;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (ready) ok = 0;
    end
    chk("R9 ready stays low", ok, 1);
    run[2] = 1'b1;
    wait_ready(200, cyc);
    chk("R9 recovers after restart", result, 30);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule